// File: doc/BRIEF.md
# Serial PHY Management Bus Master

This block is a master for the two-wire PHY management bus, with one clock line (`mdc`) and one bidirectional data line. Software starts a transfer by writing a single 32-bit command word. The word selects read or write and names the PHY address and the register address. For a write it also carries 16 data bits. The block then shifts a complete management frame out on the bus and clocks it with a divided copy of the system clock.

Software polls the same word back as status. The status shows the echoed command fields, a busy flag, a read-complete flag and a 16-bit data field. For a read, the data field holds the value returned by the PHY. A second, independent register holds one 5-bit PHY address for each port, packed side by side.

The divider parameter `DIV_HALF` sets the number of system clocks in each half period of `mdc`. The frame has 64 bit periods. A transfer therefore keeps the block busy for exactly 128 × `DIV_HALF` system clocks.

Top module: `mgmt_bus_master`

## Requirements
- R1: After reset, `status_rdata` is zero, `phyad_rdata` is zero, `mdc` is low and `mdio_oe` is low.
- R2: A `cmd_wr` pulse while idle is accepted. One clock later:
  - bit 28 (busy) of the status reads 1;
  - bits 25:21 echo the PHY address;
  - bits 20:16 echo the register address;
  - bit 26 echoes the opcode (1 = read, 0 = write).
- R3: Each frame starts with the following fields, sent in this order:
  - 32 ones;
  - the pair 0,1;
  - the opcode pair, which is 1,0 for a read and 0,1 for a write;
  - the 5-bit PHY address, MSB first;
  - the 5-bit register address, MSB first.
- R4: In a write frame, the header is followed by the turnaround pair 1,0 and then the data bits 15:0 of the command, MSB first. `mdio_oe` stays high for all 64 bit periods.
- R5: In a read frame, `mdio_oe` is high for the first 46 bit periods and low for the last 18.
  - Sampling: 16 bits are taken on `mdc` rising edges in bit periods 48 to 63, MSB first.
  - Result: these bits appear in status bits 15:0, and bit 27 (read complete) is set on the same clock on which busy clears.
- R6: `mdc` is low while idle. During a transfer it toggles every `DIV_HALF` clocks, so it has 64 rising edges per frame. `mdio_o` changes only together with a falling edge of `mdc`.
- R7: Busy stays set for exactly 128 × `DIV_HALF` clock cycles per accepted command.
- R8: A `cmd_wr` while busy is ignored. The running frame and the echoed fields are unchanged, and no further frame follows.
- R9: The read-complete flag clears in the clock after a command is accepted. The data field then holds the write data for a write, or zero for a read.
- R10: The port address register:
  - holds port p's address in bits 5p+4:5p;
  - reads zero above bit 5×`NPORTS`−1;
  - changes only on a `phyad_wr` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word (data 15:0, register 20:16, PHY 25:21, read 26) |
| status_rdata | output | 32 | Command echo, read complete (27), busy (28), data (15:0) |
| phyad_wr | input | 1 | Port address register write strobe |
| phyad_wdata | input | 32 | Port address register write value |
| phyad_rdata | output | 32 | Port address register contents |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in (synchronized inside) |

## Verification
Busy and the echoed fields are due one clock after the strobe, and the bench samples them at the next falling system clock. A PHY model records the line and the enable on every rising `mdc` edge. For reads, it drives reply bits on falling `mdc` edges.

Completion is due 128 × `DIV_HALF` clocks after acceptance. The monitor counts busy cycles and the spacing of `mdc` transitions exactly. It compares captured bits and final status at the first sample where busy reads low. The driver issues the next command only after that sample.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int HDR_BITS   = 46;   // preamble + start + op + phy + reg
  localparam int TA_SECOND  = 47;   // bit period before the data field
  localparam int DATA_FIRST = 48;

  localparam int F_REG_LO = 16;
  localparam int F_PHY_LO = 21;
  localparam int F_OP     = 26;
  localparam int F_VALID  = 27;
  localparam int F_BUSY   = 28;

  typedef struct packed {
    logic              is_read;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
    logic [DATA_W-1:0] data;
  } mgmt_cmd_t;

  function automatic mgmt_cmd_t decode_cmd(input logic [31:0] w);
    mgmt_cmd_t c;
    c.is_read = w[F_OP];
    c.phy     = w[F_PHY_LO +: ADDR_W];
    c.regad   = w[F_REG_LO +: ADDR_W];
    c.data    = w[DATA_W-1:0];
    return c;
  endfunction

  // Bit FRAME_BITS-1 goes on the wire first.
  function automatic logic [FRAME_BITS-1:0] build_frame(input mgmt_cmd_t c);
    logic [1:0] op;
    logic [1:0] ta;
    logic [DATA_W-1:0] tail;
    op   = c.is_read ? 2'b10 : 2'b01;
    ta   = c.is_read ? 2'b11 : 2'b10;
    tail = c.is_read ? {DATA_W{1'b1}} : c.data;
    return {{32{1'b1}}, 2'b01, op, c.phy, c.regad, ta, tail};
  endfunction

  function automatic logic [31:0] pack_status(input logic busy, input logic valid,
                                              input mgmt_cmd_t c,
                                              input logic [DATA_W-1:0] data);
    logic [31:0] s;
    s = '0;
    s[DATA_W-1:0]            = data;
    s[F_REG_LO +: ADDR_W]    = c.regad;
    s[F_PHY_LO +: ADDR_W]    = c.phy;
    s[F_OP]                  = c.is_read;
    s[F_VALID]               = valid;
    s[F_BUSY]                = busy;
    return s;
  endfunction
endpackage

// File: rtl/mgmt_mdc_gen.sv
module mgmt_mdc_gen #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick     = run && (cnt == LAST);
  assign rise_evt = tick && !mdc;
  assign fall_evt = tick && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mgmt_frame_engine.sv
module mgmt_frame_engine
  import mgmt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] start_frame,
  input  logic                  start_read,
  input  logic                  rise_evt,
  input  logic                  fall_evt,
  input  logic                  mdio_in,
  output logic                  busy,
  output logic                  done,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic [DATA_W-1:0]     rd_data
);
  localparam int IW = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] LAST_BIT = IW'(FRAME_BITS - 1);
  localparam logic [IW-1:0] REL_BIT  = IW'(HDR_BITS);
  localparam logic [IW-1:0] SMP_BIT  = IW'(DATA_FIRST);

  logic [FRAME_BITS-1:0] shreg;
  logic [IW-1:0]         idx;
  logic                  is_rd;
  logic [DATA_W-1:0]     rd_sh;
  logic                  sample_now;

  assign done       = busy && fall_evt && (idx == LAST_BIT);
  assign sample_now = busy && rise_evt && is_rd && (idx >= SMP_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      idx   <= '0;
      is_rd <= 1'b0;
      busy  <= 1'b0;
    end else if (start && !busy) begin
      shreg <= start_frame;
      idx   <= '0;
      is_rd <= start_read;
      busy  <= 1'b1;
    end else if (busy && fall_evt) begin
      shreg <= {shreg[FRAME_BITS-2:0], 1'b1};
      if (idx == LAST_BIT) busy <= 1'b0;
      else                 idx  <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rd_sh <= '0;
    else if (sample_now) rd_sh <= {rd_sh[DATA_W-2:0], mdio_in};
  end

  assign mdio_o  = busy ? shreg[FRAME_BITS-1] : 1'b1;
  assign mdio_oe = busy && !(is_rd && (idx >= REL_BIT));
  assign rd_data = rd_sh;
endmodule

// File: rtl/mgmt_phyad_bank.sv
module mgmt_phyad_bank
  import mgmt_pkg::*;
#(
  parameter int NPORTS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);
  localparam int USED = NPORTS * ADDR_W;

  logic [NPORTS-1:0][ADDR_W-1:0] field_q;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  field_q[p] <= '0;
      else if (wr) field_q[p] <= wdata[p*ADDR_W +: ADDR_W];
    end
  end

  if (USED < 32) begin : g_pad
    assign rdata = {{(32-USED){1'b0}}, field_q};
  end else begin : g_full
    assign rdata = field_q;
  end
endmodule

// File: rtl/mgmt_bus_master.sv
module mgmt_bus_master
  import mgmt_pkg::*;
#(
  parameter int DIV_HALF = 4,
  parameter int NPORTS   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] status_rdata,
  input  logic        phyad_wr,
  input  logic [31:0] phyad_wdata,
  output logic [31:0] phyad_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  initial begin
    if (DIV_HALF < 3) $error("DIV_HALF must be at least 3");
    if (NPORTS * ADDR_W > 32) $error("NPORTS too large");
  end

  logic      busy_w, done_w, accept_w, rise_w, fall_w;
  logic      valid_q, sync1, sync2;
  mgmt_cmd_t cur_q, new_cmd;
  logic [DATA_W-1:0] data_q, rd_w;

  assign new_cmd  = decode_cmd(cmd_wdata);
  assign accept_w = cmd_wr && !busy_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
    end else begin
      sync1 <= mdio_i;
      sync2 <= sync1;
    end
  end

  mgmt_mdc_gen #(.DIV_HALF(DIV_HALF)) u_mdc (
    .clk(clk), .rst_n(rst_n), .run(busy_w),
    .mdc(mdc), .rise_evt(rise_w), .fall_evt(fall_w)
  );

  mgmt_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start(accept_w),
    .start_frame(build_frame(new_cmd)), .start_read(new_cmd.is_read),
    .rise_evt(rise_w), .fall_evt(fall_w), .mdio_in(sync2),
    .busy(busy_w), .done(done_w), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_data(rd_w)
  );

  mgmt_phyad_bank #(.NPORTS(NPORTS)) u_phyad (
    .clk(clk), .rst_n(rst_n), .wr(phyad_wr), .wdata(phyad_wdata),
    .rdata(phyad_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else if (accept_w) begin
      cur_q   <= new_cmd;
      data_q  <= new_cmd.is_read ? '0 : new_cmd.data;
      valid_q <= 1'b0;
    end else if (done_w && cur_q.is_read) begin
      data_q  <= rd_w;
      valid_q <= 1'b1;
    end
  end

  assign status_rdata = pack_status(busy_w, valid_q, cur_q, data_q);
endmodule

// File: rtl/mgmt_bus_master_chk.sv
module mgmt_bus_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_wr,
  input logic        accept,
  input logic        busy,
  input logic        done,
  input logic        rd_valid,
  input logic        cmd_is_read,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [31:0] status
);
  // R8: strobe during a transfer leaves the echo alone
  a_r8_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_wr && !done |=> busy && $stable(status[26:16]));

  // R9: acceptance clears the read-complete flag
  a_r9_valid_clear: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && !rd_valid);

  // R5: read-complete appears only as a read finishes
  a_r5_valid_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $fell(busy) && cmd_is_read);

  // R5: the line is released only at a falling mdc during a read
  a_r5_oe_release: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $fell(mdio_oe) |-> $fell(mdc) && cmd_is_read);

  // R6: data changes only with a falling mdc
  a_r6_mdio_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$stable(mdio_o) |-> $fell(mdc));

  // R6: clock parked low while idle
  a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
endmodule

bind mgmt_bus_master mgmt_bus_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .accept(accept_w),
  .busy(busy_w), .done(done_w), .rd_valid(valid_q),
  .cmd_is_read(cur_q.is_read), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .status(status_rdata)
);

// File: tb/test_mgmt_bus_master.sv
module test_mgmt_bus_master;
  localparam int DIV    = 4;
  localparam int NPORTS = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] status_rdata;
  logic        phyad_wr = 1'b0;
  logic [31:0] phyad_wdata = '0;
  logic [31:0] phyad_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_checks = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  mgmt_bus_master #(.DIV_HALF(DIV), .NPORTS(NPORTS)) i_mgmt_bus_master (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .status_rdata(status_rdata), .phyad_wr(phyad_wr), .phyad_wdata(phyad_wdata),
    .phyad_rdata(phyad_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  typedef struct {
    bit          is_read;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] data;
  } exp_t;
  exp_t sb[$];

  // PHY model
  logic [63:0] cap_bits, cap_oe;
  int          phy_n = 0;
  logic [15:0] phy_resp = '0;
  bit          cap_read;

  always @(posedge mdc) begin
    if (phy_n < 64) begin
      cap_bits[63-phy_n] = mdio_o;
      cap_oe[63-phy_n]   = mdio_oe;
    end
    phy_n++;
  end

  always @(negedge mdc) begin
    cap_read = (cap_bits[29:28] == 2'b10);
    if (cap_read && phy_n == 47)                   mdio_i <= 1'b0;
    else if (cap_read && phy_n >= 48 && phy_n < 64) mdio_i <= phy_resp[63-phy_n];
    else                                            mdio_i <= 1'b1;
  end

  function automatic logic [63:0] exp_frame(input exp_t e);
    logic [63:0] f;
    f = {32'hFFFF_FFFF, 2'b01, (e.is_read ? 2'b10 : 2'b01), e.phy, e.regad,
         2'b10, e.data};
    return f;
  endfunction

  // Driver: accept a command and push the expected result
  task automatic do_cmd(input bit rd, input logic [4:0] phy,
                        input logic [4:0] regad, input logic [15:0] d);
    exp_t e;
    @(negedge clk);
    while (status_rdata[28]) @(negedge clk);
    @(negedge clk);
    e.is_read = rd; e.phy = phy; e.regad = regad; e.data = d;
    sb.push_back(e);
    phy_n = 0;
    cmd_wdata = {5'b0, 1'b0, 1'b0, rd, phy, regad, d};
    cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    check(status_rdata[28] == 1'b1, "R2", "busy after accept", status_rdata[28], 1);
    check(status_rdata[25:21] == phy && status_rdata[20:16] == regad &&
          status_rdata[26] == rd, "R2", "echoed fields",
          status_rdata[26:16], {rd, phy, regad});
    check(status_rdata[27] == 1'b0 && status_rdata[15:0] == (rd ? 16'h0 : d),
          "R9", "valid cleared / data on accept",
          status_rdata[27:0] & 28'h800FFFF, {rd ? 16'h0 : d});
  endtask

  task automatic wait_idle;
    @(negedge clk);
    while (status_rdata[28] || sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: measure busy span and mdc spacing, compare at completion
  initial begin
    int busy_cyc, since;
    bit last_mdc, was_busy, spacing_ok;
    int edges;
    exp_t e;
    was_busy = 0; busy_cyc = 0; since = 0; last_mdc = 0; spacing_ok = 1; edges = 0;
    forever begin
      @(negedge clk);
      if (status_rdata[28]) begin
        if (!was_busy) begin
          busy_cyc = 0; since = 0; spacing_ok = 1; edges = 0; last_mdc = mdc;
        end else begin
          since++;
          if (mdc != last_mdc) begin
            if (since != DIV) spacing_ok = 0;
            if (mdc) edges++;
            since = 0;
            last_mdc = mdc;
          end
        end
        busy_cyc++;
        was_busy = 1;
      end else if (was_busy) begin
        was_busy = 0;
        if (sb.size() == 0) begin
          check(0, "R8", "frame with no accepted command", 0, 1);
        end else begin
          e = sb.pop_front();
          check(busy_cyc == 128*DIV, "R7", "busy length", busy_cyc, 128*DIV);
          check(spacing_ok && edges == 64 && mdc == 1'b0, "R6", "mdc spacing/edges",
                edges, 64);
          check(cap_bits[63:18] == exp_frame(e)[63:18], "R3", "frame header",
                cap_bits[63:18], exp_frame(e)[63:18]);
          if (e.is_read) begin
            check(cap_oe == {{46{1'b1}}, 18'h0}, "R5", "oe pattern", cap_oe,
                  {{46{1'b1}}, 18'h0});
            check(status_rdata[27] == 1'b1 && status_rdata[15:0] == phy_resp,
                  "R5", "read data/valid", status_rdata[27:0] & 28'h800FFFF,
                  {12'h800, phy_resp});
          end else begin
            check(cap_bits[17:0] == {2'b10, e.data}, "R4", "turnaround+data",
                  cap_bits[17:0], {2'b10, e.data});
            check(cap_oe == '1, "R4", "oe all frame", cap_oe, '1);
            check(status_rdata[27] == 1'b0 && status_rdata[15:0] == e.data,
                  "R4", "write status", status_rdata[27:0] & 28'h800FFFF, e.data);
          end
          check(status_rdata[26:16] == {e.is_read, e.phy, e.regad}, "R8",
                "echo kept to end", status_rdata[26:16], {e.is_read, e.phy, e.regad});
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(status_rdata == 32'h0, "R1", "status at reset", status_rdata, 0);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R1", "bus idle at reset", {mdc, mdio_oe}, 0);
    check(phyad_rdata == 32'h0, "R1", "port register at reset", phyad_rdata, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    do_cmd(0, 5'h11, 5'h04, 16'hBEEF);
    wait_idle();

    phy_resp = 16'h1234;
    do_cmd(1, 5'h03, 5'h1F, 16'h0);
    wait_idle();

    // R8: strobe during a read, then check nothing more runs
    phy_resp = 16'hA5C3;
    do_cmd(1, 5'h1E, 5'h00, 16'h0);
    repeat (200) @(negedge clk);
    cmd_wdata = {5'b0, 1'b0, 1'b0, 1'b0, 5'h07, 5'h09, 16'h5555};
    cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    check(status_rdata[26:16] == {1'b1, 5'h1E, 5'h00}, "R8", "echo after ignored strobe",
          status_rdata[26:16], {1'b1, 5'h1E, 5'h00});
    wait_idle();
    repeat (4*DIV) @(negedge clk);
    check(status_rdata[28] == 1'b0 && mdc == 1'b0, "R8", "no frame after ignored strobe",
          {status_rdata[28], mdc}, 0);

    // R9 valid cleared by a following write
    do_cmd(0, 5'h00, 5'h00, 16'h0000);
    wait_idle();
    do_cmd(0, 5'h1F, 5'h1F, 16'hFFFF);
    wait_idle();

    // R10 port address register
    @(negedge clk);
    phyad_wdata = 32'hFFFF_FFFF; phyad_wr = 1'b1;
    @(negedge clk);
    phyad_wr = 1'b0;
    check(phyad_rdata == 32'h0000_03FF, "R10", "fields and zero padding",
          phyad_rdata, 32'h3FF);
    phyad_wdata = 32'h0000_0061; phyad_wr = 1'b1;
    @(negedge clk);
    phyad_wr = 1'b0;
    phyad_wdata = 32'h0000_0155;
    repeat (3) @(negedge clk);
    check(phyad_rdata[4:0] == 5'd1 && phyad_rdata[9:5] == 5'd3, "R10",
          "per-port fields, held without strobe", phyad_rdata, 32'h61);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule